// File: doc/BRIEF.md
# Parallel Flash Command Interface Controller

This block is a synchronous command decoder and read-mode state machine placed in front of a NOR flash array. Each bus write cycle presents an address and a 16-bit data word. The low byte of the data is decoded as a command, or it is consumed as an operand when a multi-cycle sequence is in progress. The controller tracks the current read mode: array, status, identifier or query. The read data port returns array, identifier or query data from outside the block, or the internal 8-bit status byte, depending on that mode.

Four two-step operations exist: word program, block erase, buffered program and enhanced buffered program. Each one ends in a one-cycle start pulse to the program/erase engine, which carries an operation code and the latched address and data. The engine is modelled here by a busy timer of `LAT` cycles. While the engine runs, the write path accepts only the status-read, suspend and resume commands, and the enhanced mode accepts no command at all. A bad confirm sets two sticky error bits and forces status mode. In buffered program, each streamed word is echoed on a registered buffer-write port.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After reset the read mode is array (rd_mode 0: 0 array, 1 status, 2 identifier, 3 query), rd_data equals arr_rdata, no start pulse is issued and the status byte is 0x80. Status bit 7 is ready, bit 6 is suspended, bit 5 is erase error, bit 4 is program error, and bits 3..0 read zero.
- R2: Write data 0xFF selects array reads (all 16 bits of arr_rdata). Write data 0x70 selects status reads, with the status byte on rd_data[7:0] and zero above it.
- R3: Write data 0x90 selects identifier reads (all 16 bits of id_rdata). Write data 0x98 selects query reads, with qry_rdata on rd_data[7:0] and zero above it.
- R4: 0x40 followed by any write produces a one-cycle eng_start in the cycle after the second write, with eng_op 0 and the second write's address and data. Every setup code switches the read mode to status.
- R5: Status bit 7 is low from the start pulse until LAT clock edges after the starting write, and then goes high.
- R6: 0x20 followed by 0xD0 starts eng_op 1 at the confirm's address. 0x20 followed by any other value starts nothing, sets status bits 5 and 4, and leaves the mode at status.
- R7: Status bits 5 and 4 are cleared only by 0x50. Other commands and the completion of later operations leave them set.
- R8: 0xE8, then a count-minus-one word, then that many data writes, each echoed one cycle later on buf_wr/buf_addr/buf_data, then 0xD0, starts eng_op 2 with the count write's address and with eng_data equal to the count minus one.
- R9: A buffered count-minus-one of BUF_MAX or more, or a value other than 0xD0 after the last word, sets status bits 5 and 4 and starts nothing.
- R10: 0x80 then 0xD0 starts eng_op 3. Until that operation completes, every write is ignored, including 0x70, 0xB0 and 0xFF. 0x80 followed by any value other than 0xD0 sets status bits 5 and 4.
- R11: While word program, erase or buffered program runs, only 0x70, 0xB0 (suspend) and 0xD0 (resume, only while suspended) take effect. Mode changes, 0x50 and setup codes are dropped.
- R12: 0xB0 sets status bit 6 and freezes the timer, starting at the edge where 0xB0 is written. 0xD0 clears bit 6, and the timer counts again from that edge.
- R13: After an operation completes, the read mode remains status until 0xFF is written.
- R14: With no sequence pending, unknown codes and a lone 0xD0 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Bus write cycle strobe |
| wr_addr | input | AW | Write address |
| wr_data | input | 16 | Write data; low byte decoded as command |
| arr_rdata | input | 16 | Array read data |
| id_rdata | input | 16 | Identifier/configuration read data |
| qry_rdata | input | 8 | Query table read data |
| rd_data | output | 16 | Read data selected by the current mode |
| rd_mode | output | 2 | Current read mode |
| eng_start | output | 1 | One-cycle engine start pulse |
| eng_op | output | 2 | Engine operation: 0 word, 1 erase, 2 buffered, 3 enhanced |
| eng_addr | output | AW | Latched operation address |
| eng_data | output | 16 | Latched operation data |
| buf_wr | output | 1 | Buffered word write strobe |
| buf_addr | output | AW | Buffered word address |
| buf_data | output | 16 | Buffered word data |

## Verification
The bench builds the block with LAT = 12 and BUF_MAX = 8. The short latency allows an exact count of busy cycles, and a suspend can be placed at a known remaining count. The small buffer limit allows a full buffered program to be streamed in a few writes, and an over-limit count (8) to be tried next to it. Word program, erase and the enhanced mode each run to completion, so the sticky error bits and the status mode that persists after completion are observed across several operations.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

  typedef enum logic [1:0] {RM_ARRAY, RM_STATUS, RM_IDENT, RM_QUERY} rd_mode_e;
  typedef enum logic [1:0] {OP_WORD, OP_ERASE, OP_BUFFER, OP_ENHANCED} eng_op_e;
  typedef enum logic [2:0] {
    SQ_IDLE, SQ_WORD_DATA, SQ_ERASE_CONF, SQ_BUF_COUNT,
    SQ_BUF_WORDS, SQ_BUF_CONF, SQ_ENH_CONF
  } seq_e;

  localparam logic [7:0] CMD_ARRAY    = 8'hFF;
  localparam logic [7:0] CMD_STATUS   = 8'h70;
  localparam logic [7:0] CMD_IDENT    = 8'h90;
  localparam logic [7:0] CMD_QUERY    = 8'h98;
  localparam logic [7:0] CMD_CLR_ERR  = 8'h50;
  localparam logic [7:0] CMD_WORD     = 8'h40;
  localparam logic [7:0] CMD_ERASE    = 8'h20;
  localparam logic [7:0] CMD_BUFFER   = 8'hE8;
  localparam logic [7:0] CMD_ENHANCED = 8'h80;
  localparam logic [7:0] CMD_SUSPEND  = 8'hB0;
  localparam logic [7:0] CMD_CONFIRM  = 8'hD0;

  // Buffered count check: operand carries word count minus one
  function automatic logic count_fits(input logic [15:0] cm1, input int unsigned max_words);
    return 32'(cm1) < max_words;
  endfunction

  // Status byte layout
  function automatic logic [7:0] pack_status(input logic busy, input logic susp,
                                             input logic [1:0] err);
    return {~busy, susp, err, 4'b0000};
  endfunction

  // Read data selection per mode
  function automatic logic [15:0] pick_read(input rd_mode_e m, input logic [15:0] arr,
                                            input logic [7:0] sr, input logic [15:0] id,
                                            input logic [7:0] q);
    case (m)
      RM_ARRAY:  return arr;
      RM_STATUS: return {8'h00, sr};
      RM_IDENT:  return id;
      default:   return {8'h00, q};
    endcase
  endfunction

endpackage

// File: rtl/flash_busy_timer.sv
module flash_busy_timer #(
  parameter int unsigned LAT = 64,
  localparam int unsigned CW = $clog2(LAT + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          freeze,
  output logic          busy,
  output logic [CW-1:0] cnt
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     cnt <= '0;
    else if (start)                 cnt <= CW'(LAT);
    else if (busy && !freeze)       cnt <= cnt - 1'b1;
  end

  assign busy = (cnt != '0);

endmodule

// File: rtl/flash_status_reg.sv
module flash_status_reg
  import flash_cmd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       busy,
  input  logic       set_err,
  input  logic       clr_err,
  input  logic       susp_set,
  input  logic       susp_clr,
  output logic [7:0] sr,
  output logic       suspended
);

  logic [1:0] err_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q     <= 2'b00;
      suspended <= 1'b0;
    end else begin
      if (set_err)      err_q <= 2'b11;
      else if (clr_err) err_q <= 2'b00;
      if (susp_set)      suspended <= 1'b1;
      else if (susp_clr) suspended <= 1'b0;
    end
  end

  assign sr = pack_status(busy, suspended, err_q);

endmodule

// File: rtl/flash_cmd_decode.sv
module flash_cmd_decode
  import flash_cmd_pkg::*;
#(
  parameter int unsigned AW      = 25,
  parameter int unsigned BUF_MAX = 512,
  localparam int unsigned NW     = $clog2(BUF_MAX + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [15:0]   wr_data,
  input  logic          busy,
  input  logic          suspended,
  output logic          start_req,
  output eng_op_e       start_op,
  output logic [AW-1:0] start_addr,
  output logic [15:0]   start_data,
  output logic          seq_err,
  output logic          clr_evt,
  output logic          susp_evt,
  output logic          resume_evt,
  output logic          word_evt,
  output rd_mode_e      rd_mode
);

  seq_e          seq_q, seq_d;
  rd_mode_e      mode_d;
  eng_op_e       op_q, op_d;
  logic [AW-1:0] base_q, base_d;
  logic [15:0]   cm1_q, cm1_d;
  logic [NW-1:0] left_q, left_d;
  logic [7:0]    cmd;

  assign cmd = wr_data[7:0];

  always_comb begin
    seq_d      = seq_q;
    mode_d     = rd_mode;
    op_d       = op_q;
    base_d     = base_q;
    cm1_d      = cm1_q;
    left_d     = left_q;
    start_req  = 1'b0;
    start_op   = op_q;
    start_addr = wr_addr;
    start_data = wr_data;
    seq_err    = 1'b0;
    clr_evt    = 1'b0;
    susp_evt   = 1'b0;
    resume_evt = 1'b0;
    word_evt   = 1'b0;
    if (wr_en) begin
      if (busy) begin
        if (op_q != OP_ENHANCED) begin
          if (cmd == CMD_STATUS)                     mode_d = RM_STATUS;
          else if (!suspended && cmd == CMD_SUSPEND) susp_evt = 1'b1;
          else if (suspended && cmd == CMD_CONFIRM)  resume_evt = 1'b1;
        end
      end else begin
        case (seq_q)
          SQ_IDLE: begin
            case (cmd)
              CMD_ARRAY:    mode_d = RM_ARRAY;
              CMD_STATUS:   mode_d = RM_STATUS;
              CMD_IDENT:    mode_d = RM_IDENT;
              CMD_QUERY:    mode_d = RM_QUERY;
              CMD_CLR_ERR:  clr_evt = 1'b1;
              CMD_WORD:     begin mode_d = RM_STATUS; seq_d = SQ_WORD_DATA;  end
              CMD_ERASE:    begin mode_d = RM_STATUS; seq_d = SQ_ERASE_CONF; end
              CMD_BUFFER:   begin mode_d = RM_STATUS; seq_d = SQ_BUF_COUNT;  end
              CMD_ENHANCED: begin mode_d = RM_STATUS; seq_d = SQ_ENH_CONF;   end
              default: ;
            endcase
          end
          SQ_WORD_DATA: begin
            start_req = 1'b1;
            start_op  = OP_WORD;
            seq_d     = SQ_IDLE;
          end
          SQ_ERASE_CONF: begin
            if (cmd == CMD_CONFIRM) begin
              start_req = 1'b1;
              start_op  = OP_ERASE;
            end else begin
              seq_err = 1'b1;
            end
            seq_d = SQ_IDLE;
          end
          SQ_BUF_COUNT: begin
            if (count_fits(wr_data, BUF_MAX)) begin
              base_d = wr_addr;
              cm1_d  = wr_data;
              left_d = wr_data[NW-1:0] + 1'b1;
              seq_d  = SQ_BUF_WORDS;
            end else begin
              seq_err = 1'b1;
              seq_d   = SQ_IDLE;
            end
          end
          SQ_BUF_WORDS: begin
            word_evt = 1'b1;
            left_d   = left_q - 1'b1;
            if (left_q == NW'(1)) seq_d = SQ_BUF_CONF;
          end
          SQ_BUF_CONF: begin
            if (cmd == CMD_CONFIRM) begin
              start_req  = 1'b1;
              start_op   = OP_BUFFER;
              start_addr = base_q;
              start_data = cm1_q;
            end else begin
              seq_err = 1'b1;
            end
            seq_d = SQ_IDLE;
          end
          SQ_ENH_CONF: begin
            if (cmd == CMD_CONFIRM) begin
              start_req = 1'b1;
              start_op  = OP_ENHANCED;
            end else begin
              seq_err = 1'b1;
            end
            seq_d = SQ_IDLE;
          end
          default: seq_d = SQ_IDLE;
        endcase
        if (seq_err) mode_d = RM_STATUS;
        if (start_req) op_d = start_op;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seq_q   <= SQ_IDLE;
      rd_mode <= RM_ARRAY;
      op_q    <= OP_WORD;
      base_q  <= '0;
      cm1_q   <= '0;
      left_q  <= '0;
    end else begin
      seq_q   <= seq_d;
      rd_mode <= mode_d;
      op_q    <= op_d;
      base_q  <= base_d;
      cm1_q   <= cm1_d;
      left_q  <= left_d;
    end
  end

endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
  import flash_cmd_pkg::*;
#(
  parameter int unsigned AW      = 25,
  parameter int unsigned BUF_MAX = 512,
  parameter int unsigned LAT     = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [15:0]   wr_data,
  input  logic [15:0]   arr_rdata,
  input  logic [15:0]   id_rdata,
  input  logic [7:0]    qry_rdata,
  output logic [15:0]   rd_data,
  output logic [1:0]    rd_mode,
  output logic          eng_start,
  output logic [1:0]    eng_op,
  output logic [AW-1:0] eng_addr,
  output logic [15:0]   eng_data,
  output logic          buf_wr,
  output logic [AW-1:0] buf_addr,
  output logic [15:0]   buf_data
);

  localparam int unsigned CW = $clog2(LAT + 1);

  // Named internal events (also observed by the bound checker)
  logic          busy, suspended, freeze;
  logic          start_req, seq_err, clr_evt, susp_evt, resume_evt, word_evt;
  eng_op_e       start_op;
  logic [AW-1:0] start_addr;
  logic [15:0]   start_data;
  rd_mode_e      mode;
  logic [7:0]    sr;
  logic [CW-1:0] tmr_cnt;

  flash_cmd_decode #(.AW(AW), .BUF_MAX(BUF_MAX)) u_dec (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .busy(busy), .suspended(suspended),
    .start_req(start_req), .start_op(start_op), .start_addr(start_addr),
    .start_data(start_data), .seq_err(seq_err), .clr_evt(clr_evt),
    .susp_evt(susp_evt), .resume_evt(resume_evt), .word_evt(word_evt),
    .rd_mode(mode)
  );

  assign freeze = (suspended | susp_evt) & ~resume_evt;

  flash_busy_timer #(.LAT(LAT)) u_tmr (
    .clk(clk), .rst_n(rst_n), .start(start_req), .freeze(freeze),
    .busy(busy), .cnt(tmr_cnt)
  );

  flash_status_reg u_sr (
    .clk(clk), .rst_n(rst_n), .busy(busy), .set_err(seq_err), .clr_err(clr_evt),
    .susp_set(susp_evt), .susp_clr(resume_evt), .sr(sr), .suspended(suspended)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      eng_start <= 1'b0;
      eng_op    <= 2'd0;
      eng_addr  <= '0;
      eng_data  <= '0;
      buf_wr    <= 1'b0;
      buf_addr  <= '0;
      buf_data  <= '0;
    end else begin
      eng_start <= start_req;
      buf_wr    <= word_evt;
      if (start_req) begin
        eng_op   <= start_op;
        eng_addr <= start_addr;
        eng_data <= start_data;
      end
      if (word_evt) begin
        buf_addr <= wr_addr;
        buf_data <= wr_data;
      end
    end
  end

  assign rd_mode = mode;
  assign rd_data = pick_read(mode, arr_rdata, sr, id_rdata, qry_rdata);

endmodule

// File: rtl/flash_cmd_ctrl_chk.sv
module flash_cmd_ctrl_chk #(
  parameter int unsigned CW = 7
) (
  input logic          clk,
  input logic          rst_n,
  input logic          eng_start,
  input logic [7:0]    sr,
  input logic [1:0]    rd_mode,
  input logic          busy,
  input logic          start_req,
  input logic          clr_evt,
  input logic          resume_evt,
  input logic [CW-1:0] tmr_cnt,
  input logic          buf_wr
);

  AST_START_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |=> !eng_start); // R4
  AST_BUSY_AT_START: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |-> !sr[7]); // R5
  AST_STATUS_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |-> (rd_mode == 2'd1)); // R13
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (sr[5] && !clr_evt) |=> sr[5]); // R7
  AST_NO_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !start_req); // R11
  AST_SUSPEND_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (sr[6] && !resume_evt) |=> (tmr_cnt == $past(tmr_cnt))); // R12
  AST_BUF_WHILE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    buf_wr |-> !busy); // R8

endmodule

bind flash_cmd_ctrl flash_cmd_ctrl_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .eng_start(eng_start), .sr(sr), .rd_mode(rd_mode),
  .busy(busy), .start_req(start_req), .clr_evt(clr_evt), .resume_evt(resume_evt),
  .tmr_cnt(tmr_cnt), .buf_wr(buf_wr)
);

// File: tb/flash_cmd_ctrl_tb.sv
module flash_cmd_ctrl_tb;

  localparam int unsigned AW = 25;
  localparam int unsigned BM = 8;
  localparam int unsigned LT = 12;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [15:0]   wr_data = '0;
  logic [15:0]   arr_rdata = 16'hA5C3;
  logic [15:0]   id_rdata = 16'h1234;
  logic [7:0]    qry_rdata = 8'h5A;
  logic [15:0]   rd_data;
  logic [1:0]    rd_mode;
  logic          eng_start, buf_wr;
  logic [1:0]    eng_op;
  logic [AW-1:0] eng_addr, buf_addr;
  logic [15:0]   eng_data, buf_data;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  flash_cmd_ctrl #(.AW(AW), .BUF_MAX(BM), .LAT(LT)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .arr_rdata(arr_rdata), .id_rdata(id_rdata), .qry_rdata(qry_rdata),
    .rd_data(rd_data), .rd_mode(rd_mode), .eng_start(eng_start), .eng_op(eng_op),
    .eng_addr(eng_addr), .eng_data(eng_data), .buf_wr(buf_wr), .buf_addr(buf_addr),
    .buf_data(buf_data)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Called at a negedge; returns at the negedge after the write edge
  task automatic wr(input logic [AW-1:0] a, input logic [15:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wait_ready(output int n);
    n = 0;
    while (!rd_data[7] && n < 1000) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic t_reset();
    chk("R1 mode after reset", rd_mode, 0);
    chk("R1 array data after reset", rd_data, 16'hA5C3);
    chk("R1 no start after reset", eng_start, 0);
    wr(0, 16'h0070);
    chk("R1 status after reset", rd_data, 16'h0080);
  endtask

  task automatic t_modes();
    wr(0, 16'h00FF);
    chk("R2 array read", rd_data, 16'hA5C3);
    wr(0, 16'h0070);
    chk("R2 status read", rd_data, 16'h0080);
    wr(0, 16'h0090);
    chk("R3 identifier read", rd_data, 16'h1234);
    wr(0, 16'h0098);
    chk("R3 query read", rd_data, 16'h005A);
    wr(0, 16'h0033);
    chk("R14 unknown code ignored", rd_data, 16'h005A);
    wr(0, 16'h00D0);
    chk("R14 lone confirm mode", rd_data, 16'h005A);
    chk("R14 lone confirm no start", eng_start, 0);
  endtask

  task automatic t_word();
    int n;
    wr(0, 16'h00FF);
    wr(0, 16'h0040);
    chk("R4 setup forces status", rd_data, 16'h0080);
    wr(25'h123, 16'hBEEF);
    chk("R4 start pulse", eng_start, 1);
    chk("R4 op", eng_op, 0);
    chk("R4 addr", eng_addr, 25'h123);
    chk("R4 data", eng_data, 16'hBEEF);
    chk("R5 busy at start", rd_data, 16'h0000);
    @(negedge clk);
    chk("R4 pulse one cycle", eng_start, 0);
    wait_ready(n);
    chk("R5 busy length", n + 1, LT);
    chk("R13 stays status", rd_mode, 1);
    wr(0, 16'h00FF);
    chk("R13 array after FF", rd_data, 16'hA5C3);
  endtask

  task automatic t_erase();
    int n;
    wr(0, 16'h0020);
    wr(25'h40000, 16'h00D0);
    chk("R6 erase start", eng_start, 1);
    chk("R6 erase op", eng_op, 1);
    chk("R6 erase addr", eng_addr, 25'h40000);
    wait_ready(n);
    wr(0, 16'h0020);
    wr(25'h40000, 16'h0077);
    chk("R6 bad confirm no start", eng_start, 0);
    chk("R6 bad confirm sets err", rd_data, 16'h00B0);
    chk("R6 bad confirm status mode", rd_mode, 1);
    wr(0, 16'h00FF);
    wr(0, 16'h0090);
    wr(0, 16'h0070);
    chk("R7 err survives commands", rd_data, 16'h00B0);
    wr(0, 16'h0040);
    wr(25'h8, 16'h1111);
    wait_ready(n);
    chk("R7 err survives completion", rd_data, 16'h00B0);
    wr(0, 16'h0050);
    chk("R7 clear err", rd_data, 16'h0080);
  endtask

  task automatic t_buffer();
    int n;
    wr(25'h200, 16'h00E8);
    wr(25'h200, 16'h0002);
    for (int i = 0; i < 3; i++) begin
      wr(25'h200 + AW'(i), 16'hC000 + 16'(i));
      chk("R8 buf_wr", buf_wr, 1);
      chk("R8 buf_addr", buf_addr, 25'h200 + i);
      chk("R8 buf_data", buf_data, 16'hC000 + i);
    end
    chk("R8 no start before confirm", eng_start, 0);
    wr(25'h200, 16'h00D0);
    chk("R8 start", eng_start, 1);
    chk("R8 op", eng_op, 2);
    chk("R8 addr", eng_addr, 25'h200);
    chk("R8 count", eng_data, 2);
    wait_ready(n);
    wr(0, 16'h00E8);
    wr(0, 16'(BM));
    chk("R9 count too big err", rd_data, 16'h00B0);
    wr(0, 16'h00D0);
    chk("R9 no start after overflow", eng_start, 0);
    wr(0, 16'h0050);
    wr(0, 16'h00E8);
    wr(0, 16'h0000);
    wr(0, 16'h4444);
    wr(0, 16'h0055);
    chk("R9 missing confirm no start", eng_start, 0);
    chk("R9 missing confirm err", rd_data, 16'h00B0);
    wr(0, 16'h0050);
  endtask

  task automatic t_busy();
    int n;
    wr(0, 16'h0040);
    wr(25'h9, 16'h2222);
    wr(0, 16'h00FF);
    chk("R11 FF ignored busy", rd_data, 16'h0000);
    wr(0, 16'h0090);
    chk("R11 90 ignored busy", rd_data, 16'h0000);
    wr(0, 16'h0020);
    wait_ready(n);
    wr(0, 16'h00D0);
    chk("R11 setup while busy dropped", eng_start, 0);
    wr(0, 16'h00FF);
  endtask

  task automatic t_suspend();
    int n;
    wr(0, 16'h0040);
    wr(25'h3, 16'h3333);
    idle(2);
    wr(0, 16'h00B0);
    chk("R12 suspended flag", rd_data, 16'h0040);
    idle(3 * LT);
    chk("R12 stays suspended", rd_data, 16'h0040);
    wr(0, 16'h00D0);
    chk("R12 resume clears flag", rd_data, 16'h0000);
    wait_ready(n);
    chk("R12 remaining time", n, LT - 3);
    wr(0, 16'h00FF);
  endtask

  task automatic t_enhanced();
    int n;
    wr(0, 16'h0080);
    wr(25'h7, 16'h00D0);
    chk("R10 start", eng_start, 1);
    chk("R10 op", eng_op, 3);
    wr(0, 16'h00B0);
    chk("R10 suspend ignored", rd_data, 16'h0000);
    wr(0, 16'h00FF);
    chk("R10 FF ignored", rd_mode, 1);
    wait_ready(n);
    chk("R10 done status", rd_data, 16'h0080);
    wr(0, 16'h0080);
    wr(0, 16'h0012);
    chk("R10 bad confirm err", rd_data, 16'h00B0);
    chk("R10 bad confirm no start", eng_start, 0);
    wr(0, 16'h0050);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_modes();
    t_word();
    t_erase();
    t_buffer();
    t_busy();
    t_suspend();
    t_enhanced();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule